// File: doc/BRIEF.md
# Receive Byte FIFO with Buffer Write Sequencer

This block sits between a serial byte receiver and a memory-style write port. Received bytes enter a small internal FIFO. From there they are written, at most one per clock, to consecutive addresses. Writing starts at a base address that is latched by a command. It stops once a latched byte limit has been reached. Three command pulses drive the block: begin, halt and drain. It reports three single-cycle events: buffer begun, buffer ended and receiver quiet. A live count of the bytes written into the current buffer is always visible. A ready-to-send output warns the far end early, before the FIFO can overflow.

Software uses it as follows. It programs a base address and a limit, then pulses begin and waits for the buffer-ended event. An optional chaining mode opens the next buffer automatically when the current one fills. Chaining uses whatever base address and limit are on the inputs at that moment. After a halt, the drain command moves any bytes left in the FIFO into a fresh buffer. It also closes that buffer, even when nothing was left to move.

Top module: `rxdma_ctrl`

## Requirements
- R1: While reset is held and just after it: `mem_we`, `ev_started`, `ev_end`, `ev_rxto` and `rts_o` are 0 and `amount` is 0.
- R2: A begin pulse does three things: it latches `ptr_in` and `max_in`, clears `amount`, and raises `ev_started` for one cycle on the next clock. Stored bytes are then written in arrival order to `ptr + n`, where n counts from 0, at most one per clock. Each write raises `amount` by one.
- R3: With `flow_en` = 1, `rts_o` is 1 only while reception is active and the FIFO holds fewer than 4 of its 8 bytes. It falls once 4 bytes are held, and after a halt.
- R4: A byte offered while the FIFO holds 8 bytes is discarded and never written.
- R5: `ev_end` pulses once `amount` equals the latched limit, and no write ever goes past the limit. Without chaining, bytes keep entering the FIFO after the end, and nothing is written until the next begin.
- R6: With `chain_en` = 1, a buffer that fills ends and restarts in the same step. `ev_started` pulses together with `ev_end`, and the new buffer uses the `ptr_in` and `max_in` values present at that clock.
- R7: A halt pulse is followed one cycle later by `ev_end` and in the next cycle by `ev_rxto`. The block is then idle.
- R8: A drain pulse (when idle) latches `ptr_in`/`max_in` and clears `amount`. It then writes FIFO bytes until the FIFO is empty or the limit is reached, and pulses `ev_end` in every case, including an empty FIFO. Bytes beyond the limit stay in the FIFO for a later drain.
- R9: With `flow_en` = 0, `rts_o` stays 0 at all times.
- R10: Bytes offered while idle are not stored: a following drain writes nothing and reports `amount` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| start_cmd | input | 1 | Begin pulse |
| stop_cmd | input | 1 | Halt pulse |
| flush_cmd | input | 1 | Drain pulse |
| ptr_in | input | AW | Buffer base address to latch |
| max_in | input | CW | Buffer byte limit to latch |
| flow_en | input | 1 | Enables the ready-to-send output |
| chain_en | input | 1 | End-to-begin chaining |
| mem_we | output | 1 | Buffer write strobe |
| mem_addr | output | AW | Buffer write address |
| mem_wdata | output | 8 | Buffer write data |
| rts_o | output | 1 | Ready-to-send, 1 = far end may send |
| ev_started | output | 1 | Buffer begun event |
| ev_end | output | 1 | Buffer ended event |
| ev_rxto | output | 1 | Receiver quiet event after halt |
| amount | output | CW | Bytes written into current buffer |

## Verification
The write path is exercised in four ways:
- Random limits and spaced bytes test address stepping and end detection.
- Back-to-back bytes under chaining show whether the second buffer takes the address presented at the restart or the one latched earlier.
- A zero-limit begin parks the FIFO, so the 4-byte flow-control threshold and the overflow loss can each be seen byte by byte.
- Drains into limits below, above and at an empty fill level separate leftover retention from the unconditional end event.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic [2:0] {
    RS_IDLE,
    RS_RUN,
    RS_HOLD,
    RS_STOP_END,
    RS_STOP_TO,
    RS_FLUSH
  } rx_state_e;
endpackage

// File: rtl/rxdma_rst_sync.sv
module rxdma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rxdma_fifo.sv
module rxdma_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  assign full    = (lvl_q == LW'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    lvl_d  = lvl_q;
    if (do_push) wptr_d = (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (do_pop)  rptr_d = (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   lvl_d = lvl_q + 1'b1;
      2'b01:   lvl_d = lvl_q - 1'b1;
      default: lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wptr_q == PW'(g))) mem_q[g] <= din;
    end
  end

  assign dout  = mem_q[rptr_q];
  assign level = lvl_q;
endmodule

// File: rtl/rxdma_rts.sv
module rxdma_rts #(
  parameter int DEPTH  = 8,
  parameter int MARGIN = 4,
  localparam int LW     = $clog2(DEPTH + 1),
  localparam int THRESH = DEPTH - MARGIN
) (
  input  logic          flow_en,
  input  logic          rx_en,
  input  logic [LW-1:0] level,
  output logic          rts
);
  assign rts = flow_en && rx_en && (level < LW'(THRESH));
endmodule

// File: rtl/rxdma_seq.sv
module rxdma_seq
  import rxdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_cmd,
  input  logic          stop_cmd,
  input  logic          flush_cmd,
  input  logic          chain_en,
  input  logic [AW-1:0] ptr_in,
  input  logic [CW-1:0] max_in,
  input  logic          fifo_empty,
  output logic          wr_go,
  output logic          rx_en,
  output logic [AW-1:0] wr_addr,
  output logic [CW-1:0] amt,
  output logic [CW-1:0] max_cur,
  output logic          ev_started,
  output logic          ev_end,
  output logic          ev_rxto
);
  rx_state_e     st_q, st_d;
  logic [AW-1:0] ptr_q;
  logic [CW-1:0] max_q, amt_q, amt_d;
  logic          load, full_buf;
  logic          sta_d, end_d, to_d;
  logic          sta_q, end_q, to_q;

  assign full_buf = (amt_q == max_q);

  always_comb begin
    st_d  = st_q;
    load  = 1'b0;
    wr_go = 1'b0;
    sta_d = 1'b0;
    end_d = 1'b0;
    to_d  = 1'b0;
    case (st_q)
      RS_IDLE: begin
        if (start_cmd) begin
          load = 1'b1; sta_d = 1'b1; st_d = RS_RUN;
        end else if (flush_cmd) begin
          load = 1'b1; st_d = RS_FLUSH;
        end
      end
      RS_RUN: begin
        if (stop_cmd) begin
          st_d = RS_STOP_END;
        end else if (full_buf) begin
          end_d = 1'b1;
          if (chain_en) begin
            load = 1'b1; sta_d = 1'b1;
          end else begin
            st_d = RS_HOLD;
          end
        end else if (!fifo_empty) begin
          wr_go = 1'b1;
        end
      end
      RS_HOLD: begin
        if (stop_cmd) begin
          st_d = RS_STOP_END;
        end else if (start_cmd) begin
          load = 1'b1; sta_d = 1'b1; st_d = RS_RUN;
        end
      end
      RS_STOP_END: begin
        end_d = 1'b1; st_d = RS_STOP_TO;
      end
      RS_STOP_TO: begin
        to_d = 1'b1; st_d = RS_IDLE;
      end
      RS_FLUSH: begin
        if (fifo_empty || full_buf) begin
          end_d = 1'b1; st_d = RS_IDLE;
        end else begin
          wr_go = 1'b1;
        end
      end
      default: st_d = RS_IDLE;
    endcase
  end

  always_comb begin
    if (load)       amt_d = '0;
    else if (wr_go) amt_d = amt_q + 1'b1;
    else            amt_d = amt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RS_IDLE;
      amt_q <= '0;
      sta_q <= 1'b0;
      end_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      amt_q <= amt_d;
      sta_q <= sta_d;
      end_q <= end_d;
      to_q  <= to_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      max_q <= '0;
    end else if (load) begin
      ptr_q <= ptr_in;
      max_q <= max_in;
    end
  end

  assign rx_en      = (st_q == RS_RUN) || (st_q == RS_HOLD);
  assign wr_addr    = ptr_q + AW'(amt_q);
  assign amt        = amt_q;
  assign max_cur    = max_q;
  assign ev_started = sta_q;
  assign ev_end     = end_q;
  assign ev_rxto    = to_q;
endmodule

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl #(
  parameter int AW     = 16,
  parameter int CW     = 8,
  parameter int DW     = 8,
  parameter int DEPTH  = 8,
  parameter int MARGIN = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          start_cmd,
  input  logic          stop_cmd,
  input  logic          flush_cmd,
  input  logic [AW-1:0] ptr_in,
  input  logic [CW-1:0] max_in,
  input  logic          flow_en,
  input  logic          chain_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          rts_o,
  output logic          ev_started,
  output logic          ev_end,
  output logic          ev_rxto,
  output logic [CW-1:0] amount
);
  logic          rst_i_n;
  logic          wr_go, rx_en, f_full, f_empty;
  logic [LW-1:0] f_level;
  logic [CW-1:0] max_cur;

  rxdma_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  rxdma_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_i_n),
    .push(rx_valid && rx_en), .din(rx_data),
    .pop(wr_go), .dout(mem_wdata),
    .level(f_level), .full(f_full), .empty(f_empty)
  );

  rxdma_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_i_n),
    .start_cmd(start_cmd), .stop_cmd(stop_cmd), .flush_cmd(flush_cmd),
    .chain_en(chain_en), .ptr_in(ptr_in), .max_in(max_in),
    .fifo_empty(f_empty), .wr_go(wr_go), .rx_en(rx_en),
    .wr_addr(mem_addr), .amt(amount), .max_cur(max_cur),
    .ev_started(ev_started), .ev_end(ev_end), .ev_rxto(ev_rxto)
  );

  rxdma_rts #(.DEPTH(DEPTH), .MARGIN(MARGIN)) u_rts (
    .flow_en(flow_en), .rx_en(rx_en), .level(f_level), .rts(rts_o)
  );

  assign mem_we = wr_go;

  logic unused_full;
  assign unused_full = f_full;
endmodule

// File: rtl/rxdma_ctrl_chk.sv
module rxdma_ctrl_chk #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flow_en,
  input logic          rts_o,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          ev_end,
  input logic          ev_rxto,
  input logic [CW-1:0] amount,
  input logic [CW-1:0] max_cur
);
  a_r9_rts_low_flow_off: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_en |-> !rts_o);

  a_r7_rxto_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rxto |-> $past(ev_end));

  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  a_r2_amount_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (amount == $past(amount) + 1'b1));

  a_r5_no_write_past_max: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (amount < max_cur));
endmodule

bind rxdma_ctrl rxdma_ctrl_chk #(.AW(AW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .flow_en(flow_en), .rts_o(rts_o),
  .mem_we(mem_we), .mem_addr(mem_addr), .ev_end(ev_end),
  .ev_rxto(ev_rxto), .amount(amount), .max_cur(max_cur)
);

// File: tb/rxdma_ctrl_tb_top.sv
`timescale 1ns/1ps
module rxdma_ctrl_tb_top;
  localparam int AW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rx_valid, start_cmd, stop_cmd, flush_cmd, flow_en, chain_en;
  logic [7:0]    rx_data;
  logic [AW-1:0] ptr_in;
  logic [CW-1:0] max_in;
  logic          mem_we, rts_o, ev_started, ev_end, ev_rxto;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [CW-1:0] amount;

  always #2.5 clk = ~clk;

  rxdma_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .start_cmd(start_cmd), .stop_cmd(stop_cmd), .flush_cmd(flush_cmd),
    .ptr_in(ptr_in), .max_in(max_in), .flow_en(flow_en), .chain_en(chain_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rts_o(rts_o), .ev_started(ev_started), .ev_end(ev_end),
    .ev_rxto(ev_rxto), .amount(amount)
  );

  int total = 0, bad = 0, cyc = 0;
  int n_end = 0, n_sta = 0, n_to = 0, n_wr = 0;
  int end_cyc = 0, to_cyc = 0;
  logic [7:0] bmem [int];
  logic [7:0] sent [$];

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_addr(int base, int idx);
    return (base + idx) & ((1 << AW) - 1);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mem_we) begin bmem[int'(mem_addr)] = mem_wdata; n_wr++; end
      if (ev_end)     begin n_end++; end_cyc = cyc; end
      if (ev_started) n_sta++;
      if (ev_rxto)    begin n_to++; to_cyc = cyc; end
    end
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic send_byte(logic [7:0] b);
    rx_valid = 1'b1; rx_data = b; tick(); rx_valid = 1'b0;
  endtask

  task automatic cmd_start(int p, int m);
    ptr_in = AW'(p); max_in = CW'(m); start_cmd = 1'b1; tick(); start_cmd = 1'b0;
  endtask

  task automatic cmd_flush(int p, int m);
    ptr_in = AW'(p); max_in = CW'(m); flush_cmd = 1'b1; tick(); flush_cmd = 1'b0;
  endtask

  task automatic cmd_stop();
    stop_cmd = 1'b1; tick(); stop_cmd = 1'b0;
  endtask

  task automatic wait_cnt(ref int cnt, input int target, input string tag);
    int k = 0;
    while (cnt < target && k < 500) begin tick(); k++; end
    chk(cnt >= target, tag, cnt, target);
  endtask

  task automatic check_buf(int base, int first, int len, string tag);
    for (int i = 0; i < len; i++) begin
      int a = exp_addr(base, i);
      int v = bmem.exists(a) ? int'(bmem[a]) : -1;
      chk(v == int'(sent[first + i]), tag, v, int'(sent[first + i]));
    end
  endtask

  initial begin
    int e0, s0, w0, t0, base;
    void'($urandom(32'd4711));
    rst_n = 1'b0; rx_valid = 0; rx_data = 0; start_cmd = 0; stop_cmd = 0;
    flush_cmd = 0; ptr_in = 0; max_in = 0; flow_en = 1'b1; chain_en = 1'b0;
    repeat (3) tick();
    chk(!mem_we && !ev_started && !ev_end && !ev_rxto && !rts_o && amount == 0,
        "R1 reset outputs", {mem_we, ev_started, ev_end, ev_rxto, rts_o}, 0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk(amount == 0 && !rts_o, "R1 after release", int'(amount), 0);

    // R2 basic buffer
    s0 = n_sta; e0 = n_end;
    cmd_start(16'h0100, 5);
    chk(n_sta == s0 + 1, "R2 started pulse", n_sta, s0 + 1);
    chk(amount == 0, "R2 amount cleared", int'(amount), 0);
    sent.delete();
    for (int i = 0; i < 5; i++) begin
      logic [7:0] b = 8'($urandom);
      sent.push_back(b); send_byte(b); tick();
    end
    wait_cnt(n_end, e0 + 1, "R5 end after limit");
    check_buf(16'h0100, 0, 5, "R2 buffer data");
    chk(amount == 5, "R5 amount at end", int'(amount), 5);

    // R2/R5 random rounds
    for (int r = 0; r < 6; r++) begin
      int m = 1 + int'($urandom % 6);
      base = 16'h0400 + r * 16;
      e0 = n_end; w0 = n_wr;
      sent.delete();
      cmd_start(base, m);
      for (int i = 0; i < m; i++) begin
        logic [7:0] b = 8'($urandom);
        sent.push_back(b); send_byte(b);
        repeat (int'($urandom % 3)) tick();
      end
      wait_cnt(n_end, e0 + 1, "R5 random end");
      tick(); tick();
      check_buf(base, 0, m, "R2 random data");
      chk(n_wr - w0 == m, "R5 no write past limit", n_wr - w0, m);
    end

    // R6 chaining
    chain_en = 1'b1; s0 = n_sta; e0 = n_end;
    sent.delete();
    cmd_start(16'h0200, 3);
    ptr_in = 16'h0300;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b = 8'($urandom);
      sent.push_back(b); send_byte(b);
    end
    wait_cnt(n_end, e0 + 2, "R6 two ends");
    check_buf(16'h0200, 0, 3, "R6 first buffer");
    check_buf(16'h0300, 3, 3, "R6 second buffer at new pointer");
    chk(n_sta == s0 + 3, "R6 restart started events", n_sta, s0 + 3);
    chain_en = 1'b0; t0 = n_to; e0 = n_end;
    cmd_stop();
    wait_cnt(n_to, t0 + 1, "R7 rxto after halt");
    chk(to_cyc == end_cyc + 1 && n_end == e0 + 1, "R7 end then rxto", to_cyc, end_cyc + 1);

    // R10 idle bytes ignored, R8 empty drain still ends
    repeat (3) send_byte(8'hA5);
    e0 = n_end; w0 = n_wr;
    cmd_flush(16'h0B00, 4);
    wait_cnt(n_end, e0 + 1, "R8 end on empty drain");
    chk(n_wr == w0 && amount == 0, "R10 idle bytes not stored", int'(amount), 0);

    // R3/R4 threshold and overflow
    e0 = n_end;
    cmd_start(16'h0600, 0);
    wait_cnt(n_end, e0 + 1, "R5 zero limit ends");
    tick();
    chk(rts_o == 1'b1, "R3 rts high with empty fifo", rts_o, 1);
    sent.delete();
    for (int i = 0; i < 9; i++) begin
      logic [7:0] b = 8'(8'h30 + i);
      sent.push_back(b); send_byte(b);
      if (i == 2) chk(rts_o == 1'b1, "R3 rts high at 3 held", rts_o, 1);
      if (i == 3) chk(rts_o == 1'b0, "R3 rts low at 4 held", rts_o, 0);
    end
    t0 = n_to;
    cmd_stop();
    chk(rts_o == 1'b0, "R3 rts low after halt", rts_o, 0);
    wait_cnt(n_to, t0 + 1, "R7 rxto");
    e0 = n_end; w0 = n_wr;
    cmd_flush(16'h0700, 10);
    wait_cnt(n_end, e0 + 1, "R8 drain end");
    chk(amount == 8 && n_wr - w0 == 8, "R4 overflow byte lost", int'(amount), 8);
    check_buf(16'h0700, 0, 8, "R8 drained data");

    // R8 excess stays in fifo
    e0 = n_end;
    cmd_start(16'h0800, 0);
    wait_cnt(n_end, e0 + 1, "R5 zero limit");
    sent.delete();
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b = 8'($urandom);
      sent.push_back(b); send_byte(b);
    end
    t0 = n_to; cmd_stop();
    wait_cnt(n_to, t0 + 1, "R7 rxto");
    e0 = n_end; cmd_flush(16'h0900, 4);
    wait_cnt(n_end, e0 + 1, "R8 partial drain end");
    chk(amount == 4, "R8 drain capped at limit", int'(amount), 4);
    check_buf(16'h0900, 0, 4, "R8 capped data");
    e0 = n_end; cmd_flush(16'h0A00, 5);
    wait_cnt(n_end, e0 + 1, "R8 second drain end");
    chk(amount == 2, "R8 leftover kept", int'(amount), 2);
    check_buf(16'h0A00, 4, 2, "R8 leftover data");

    // R9 flow control off
    flow_en = 1'b0; e0 = n_end;
    cmd_start(16'h0C00, 2);
    chk(rts_o == 1'b0, "R9 rts low with flow off", rts_o, 0);
    sent.delete();
    for (int i = 0; i < 2; i++) begin
      logic [7:0] b = 8'($urandom);
      sent.push_back(b); send_byte(b);
    end
    wait_cnt(n_end, e0 + 1, "R5 end with flow off");
    check_buf(16'h0C00, 0, 2, "R9 data with flow off");
    chk(rts_o == 1'b0, "R9 rts still low", rts_o, 0);
    t0 = n_to; cmd_stop();
    wait_cnt(n_to, t0 + 1, "R7 final rxto");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule